// File: doc/BRIEF.md
# Legacy Non-Maskable Interrupt Gate

This block produces the single non-maskable interrupt line of a PC-style system from two error sources: a pulse that reports a main-memory parity fault and a level from an expansion card that reports an I/O channel fault. Each source has its own enable. While that enable is active, an error seen on a rising clock edge is captured in a sticky latch. The output is the OR of the two latches, gated by a global mask.

Software reaches the block through a small I/O register interface with an address, write data, a read strobe and a write strobe. The global mask sits in a write-only register. Reads at its address never show the mask. The enables and the latch states are both visible in a control/status port, which can be read and written. A captured error can only be removed by turning its source enable off and then back on.

Top module: `sys_nmi_ctrl`

## Requirements
- R1: After reset the global mask is set (nmi_o low), both source enables are active (enable bits read 0), both latches are clear, and a read of the control/status port (address 0x061) returns 0x00.
- R2: A write to the mask address (0x070) loads the mask from bit 7 of the write data: 1 blocks nmi_o and 0 lets it through. The other data bits have no effect.
- R3: A read at the mask address returns 0x00 whatever the mask holds.
- R4: A read of the control/status port returns the parity latch in bit 7, the channel-check latch in bit 6, the channel-check enable in bit 3 and the parity enable in bit 2. All other bits read 0. io_rdata is 0x00 whenever io_rd is low.
- R5: An enable is active when its bit is 0. A high error input on a rising edge sets that source's latch only while its enable is active. The latch is visible after that edge.
- R6: A set latch stays set after its error input falls. It clears on the edge that writes 1 to its enable bit. Writing 0 again re-arms the source without setting the latch.
- R7: nmi_o is high exactly when at least one latch is set and the mask is clear. It is a level that follows the latches.
- R8: The enable bits read back correctly while the mask is set.
- R9: If a write of 1 to an enable bit and a high error input on that source fall on the same edge, the clear wins. After an enable is re-activated, an error that is still present sets the latch from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Register address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data (combinational) |
| par_err_i | input | 1 | Memory parity error indication |
| chan_chk_i | input | 1 | Expansion-bus channel check indication |
| nmi_o | output | 1 | Non-maskable interrupt level |

## Verification
The bench sweeps every combination of mask value, the two enable bits and the two error inputs. For each combination it predicts the latches, the status byte and nmi_o arithmetically. This separates the gating by each enable from the gating by the mask, and it shows any cross-coupling between the two sources. Directed sequences then cover the hold and clear cycle of a latch, a clear that lands on the same edge as an error, and mask writes whose bits other than bit 7 carry noise. These sequences separate the sticky behaviour, the priority of clear over set, and the decode of the mask bit.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
   localparam int NSRC    = 2;
   localparam int SRC_PAR = 0;
   localparam int SRC_CHK = 1;
   localparam int DATA_W  = 8;
   localparam int MASK_POS = 7;

   // enable bit position for source s (parity at 2, channel check at 3)
   function automatic int en_pos(input int s);
      return 2 + s;
   endfunction

   // latch status bit position for source s (parity at 7, channel check at 6)
   function automatic int st_pos(input int s);
      return 7 - s;
   endfunction
endpackage

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic err_i,
   input  logic en_n_i,
   input  logic clr_i,
   output logic latch_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else if (clr_i) begin
         latch_q <= 1'b0;
      end else if (!en_n_i && err_i) begin
         latch_q <= 1'b1;
      end
   end
endmodule

// File: rtl/nmi_io_regs.sv
module nmi_io_regs
   import nmi_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0070,
   parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'h0061
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [NSRC-1:0]   latch_i,
   output logic              mask_q,
   output logic [NSRC-1:0]   en_n_q,
   output logic [NSRC-1:0]   clr_o,
   output logic [DATA_W-1:0] io_rdata
);
   logic hit_mask, hit_port;
   logic wr_mask, wr_port;

   assign hit_mask = (io_addr == MASK_ADDR);
   assign hit_port = (io_addr == PORT_ADDR);
   assign wr_mask  = io_wr && hit_mask;
   assign wr_port  = io_wr && hit_port;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (wr_mask) begin
         mask_q <= io_wdata[MASK_POS];
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_en
      assign clr_o[s] = wr_port && io_wdata[en_pos(s)];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_n_q[s] <= 1'b0;
         end else if (wr_port) begin
            en_n_q[s] <= io_wdata[en_pos(s)];
         end
      end
   end

   logic [DATA_W-1:0] status;
   always_comb begin
      status = '0;
      for (int s = 0; s < NSRC; s++) begin
         status[st_pos(s)] = latch_i[s];
         status[en_pos(s)] = en_n_q[s];
      end
   end

   // mask address decodes but returns zero: the mask is never visible
   assign io_rdata = (io_rd && hit_port) ? status : '0;
endmodule

// File: rtl/sys_nmi_ctrl.sv
module sys_nmi_ctrl
   import nmi_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h0070,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [7:0]        io_rdata,
   input  logic              par_err_i,
   input  logic              chan_chk_i,
   output logic              nmi_o
);
   if (ADDR_W < 8) begin : g_bad_width
      $error("sys_nmi_ctrl: ADDR_W must be at least 8");
   end
   if (MASK_ADDR == PORT_ADDR) begin : g_bad_addr
      $error("sys_nmi_ctrl: mask and port addresses must differ");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("sys_nmi_ctrl: data path must be 8 bits");
   end

   logic              mask_q;
   logic [NSRC-1:0]   en_n_q;
   logic [NSRC-1:0]   clr;
   logic [NSRC-1:0]   src_latch;
   logic [NSRC-1:0]   err_in;

   assign err_in[SRC_PAR] = par_err_i;
   assign err_in[SRC_CHK] = chan_chk_i;

   nmi_io_regs #(
      .ADDR_W   (ADDR_W),
      .MASK_ADDR(MASK_ADDR),
      .PORT_ADDR(PORT_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wdata(io_wdata),
      .io_rd   (io_rd),
      .io_wr   (io_wr),
      .latch_i (src_latch),
      .mask_q  (mask_q),
      .en_n_q  (en_n_q),
      .clr_o   (clr),
      .io_rdata(io_rdata)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      nmi_src_latch u_latch (
         .clk    (clk),
         .rst_n  (rst_n),
         .err_i  (err_in[s]),
         .en_n_i (en_n_q[s]),
         .clr_i  (clr[s]),
         .latch_q(src_latch[s])
      );
   end

   assign nmi_o = (|src_latch) && !mask_q;
endmodule

// File: rtl/nmi_ctrl_chk.sv
module nmi_ctrl_chk
   import nmi_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h0070,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_rdata,
   input logic              nmi_o,
   input logic [NSRC-1:0]   en_n_q,
   input logic [NSRC-1:0]   src_latch
);
   logic wr_port;
   assign wr_port = io_wr && (io_addr == PORT_ADDR);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!nmi_o && src_latch == '0));

   assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == MASK_ADDR && io_wdata[MASK_POS]) |=> !nmi_o);

   assert_mask_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == MASK_ADDR) |-> (io_rdata == 8'h00));

   assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n_q[SRC_PAR] && !src_latch[SRC_PAR]) |=> !src_latch[SRC_PAR]);

   assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_latch[SRC_CHK] && !(wr_port && io_wdata[en_pos(SRC_CHK)])) |=> src_latch[SRC_CHK]);

   assert_nmi_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> (src_latch != '0));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_port && io_wdata[en_pos(SRC_PAR)]) |=> !src_latch[SRC_PAR]);
endmodule

bind sys_nmi_ctrl nmi_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .MASK_ADDR(MASK_ADDR),
   .PORT_ADDR(PORT_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_addr  (io_addr),
   .io_wdata (io_wdata),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_rdata (io_rdata),
   .nmi_o    (nmi_o),
   .en_n_q   (en_n_q),
   .src_latch(src_latch)
);

// File: tb/sys_nmi_ctrl_bench.sv
`timescale 1ns/1ps
module sys_nmi_ctrl_bench;
   localparam logic [15:0] MASK_A = 16'h0070;
   localparam logic [15:0] PORT_A = 16'h0061;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_rdata;
   logic        par_err_i = 1'b0;
   logic        chan_chk_i = 1'b0;
   logic        nmi_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sys_nmi_ctrl u_sys_nmi_ctrl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
      .par_err_i(par_err_i), .chan_chk_i(chan_chk_i), .nmi_o(nmi_o)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_wdata = '0;
   endtask

   task automatic rd_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
      io_addr = a; io_rd = 1'b1;
      #0.5;
      check(io_rdata, exp, tag);
      io_rd = 1'b0;
      #0.5;
   endtask

   function automatic logic [7:0] status(input logic pl, cl, pen, cen);
      return {pl, cl, 2'b00, cen, pen, 2'b00};
   endfunction

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({7'b0, nmi_o}, 8'h00, "R1 nmi after reset");
      rd_check(PORT_A, 8'h00, "R1 port after reset");
      rd_check(MASK_A, 8'h00, "R1/R3 mask read after reset");
      io_addr = PORT_A;
      #0.5; check(io_rdata, 8'h00, "R4 idle read data"); #0.5;

      // exhaustive sweep: mask x enables x error inputs
      for (int v = 0; v < 32; v++) begin
         logic m, pen, cen, pe, ce, pl, cl;
         m = v[4]; pen = v[3]; cen = v[2]; pe = v[1]; ce = v[0];
         wr(PORT_A, 8'h0C);
         wr(PORT_A, {4'b0, cen, pen, 2'b00});
         wr(MASK_A, {m, 7'h15});
         @(negedge clk); par_err_i = pe; chan_chk_i = ce;
         @(negedge clk); par_err_i = 1'b0; chan_chk_i = 1'b0;
         @(negedge clk);
         pl = pe && !pen; cl = ce && !cen;
         rd_check(PORT_A, status(pl, cl, pen, cen), $sformatf("R4/R5/R6/R8 status v=%0d", v));
         check({7'b0, nmi_o}, {7'b0, (pl || cl) && !m}, $sformatf("R2/R7 nmi v=%0d", v));
         rd_check(MASK_A, 8'h00, $sformatf("R3 mask read v=%0d", v));
      end

      // R6 hold, clear, re-arm
      wr(PORT_A, 8'h0C);
      wr(PORT_A, 8'h00);
      wr(MASK_A, 8'h00);
      @(negedge clk); par_err_i = 1'b1;
      @(negedge clk); par_err_i = 1'b0;
      repeat (5) @(negedge clk);
      check({7'b0, nmi_o}, 8'h01, "R6 latch holds nmi");
      wr(PORT_A, 8'h04);
      check({7'b0, nmi_o}, 8'h00, "R6 clear by disabling enable");
      rd_check(PORT_A, 8'h04, "R6 status after clear");
      wr(PORT_A, 8'h00);
      rd_check(PORT_A, 8'h00, "R6 re-arm does not set");
      @(negedge clk); chan_chk_i = 1'b1;
      @(negedge clk); chan_chk_i = 1'b0;
      rd_check(PORT_A, 8'h40, "R5 channel check sets after re-arm");

      // R2: bits other than bit 7 ignored
      wr(MASK_A, 8'h7F);
      check({7'b0, nmi_o}, 8'h01, "R2 mask write 7F leaves nmi enabled");
      wr(MASK_A, 8'h80);
      check({7'b0, nmi_o}, 8'h00, "R2 mask write 80 blocks nmi");
      rd_check(PORT_A, 8'h40, "R8 latch visible while masked");
      wr(MASK_A, 8'h00);
      check({7'b0, nmi_o}, 8'h01, "R7 nmi returns on unmask");

      // R9 clear wins over concurrent error
      wr(PORT_A, 8'h0C);
      wr(PORT_A, 8'h00);
      @(negedge clk); par_err_i = 1'b1;
      @(negedge clk);
      rd_check(PORT_A, 8'h80, "R9 parity latch set");
      wr(PORT_A, 8'h04);
      rd_check(PORT_A, 8'h04, "R9 clear wins with error high");
      wr(PORT_A, 8'h00);
      rd_check(PORT_A, 8'h00, "R9 no set on re-enable edge");
      @(negedge clk);
      rd_check(PORT_A, 8'h80, "R9 set on following edge");
      par_err_i = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule